// File: doc/BRIEF.md
# Table-Driven Opcode Decoder with Flag Gate

This block produces the control lines of a small 4-bit processor. A six-step sequencer names the current step of the instruction. A lookup table turns the pair (opcode, step) into a control word that drives the datapath. The word holds register loads, the ROM output enable, a line that puts the program counter on the ROM address, increment and load strobes for the program counter, and an ALU result enable with a two-bit operation select. The carry and zero flags are not part of the table index. Each table entry also carries two hint bits, "depends on carry" and "depends on zero". A small gate after the table uses those hints to turn the step into either a program-counter load (the jump is taken) or a program-counter increment (the operand is skipped).

The sequencer has six enumerated states: `ST_FETCH_ADDR`, `ST_FETCH_ADV`, `ST_EXEC_A`, `ST_EXEC_B`, `ST_EXEC_C` and `ST_EXEC_D`. Each clock moves it along one transition: FETCH_ADDR→FETCH_ADV, FETCH_ADV→EXEC_A, EXEC_A→EXEC_B, EXEC_B→EXEC_C, EXEC_C→EXEC_D, and the wrap EXEC_D→FETCH_ADDR. A synchronous reset forces FETCH_ADDR from any state. The control word and a one-hot copy of the step it belongs to are registered. Both change only on the rising edge, one cycle after the step and inputs that produced them.

Opcode map: 1 loads an immediate into A, 2 loads an immediate into B, 3 adds into A, 4 subtracts into A, 5 loads the output register, 6 jumps, 7 jumps if carry, 8 jumps if zero. Opcodes 0 and 9 to 15 do nothing.

Top module: `ucode_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, `ctrl_o` and `step_o` are zero after that edge. The first edge with `rst` low yields step 0 (`step_o` = 6'b000001), even if reset interrupted an instruction.
- R2: `step_o` is one-hot outside reset. It advances one bit per clock from bit 0 to bit 5 and then wraps to bit 0.
- R3: For every opcode and flag value, step 0 gives `ctrl_o` = 11'h007 (bit 0 address drive, bit 1 ROM enable, bit 2 instruction load) and step 1 gives 11'h008 (bit 3 counter increment).
- R4: Opcode 1 gives 11'h023 at step 2 (bits 0, 1 and 5, A load) and 11'h008 at step 3, for any CF and ZF.
- R5: Opcode 2 gives 11'h043 at step 2 (bits 0, 1 and 6, B load) and 11'h008 at step 3.
- R6: At step 2, opcode 3 gives 11'h120 (bit 8 ALU enable, bit 5 A load, select bits 10:9 = 00), and opcode 4 gives 11'h320 (select = 01).
- R7: Opcode 5 gives 11'h080 at step 2 (bit 7, output load).
- R8: Opcode 6 gives 11'h013 at step 2 (bits 0, 1 and 4, counter load), whatever the flags.
- R9: At step 2, opcode 7 gives 11'h013 when CF is 1 and 11'h00B (increment instead of load) when CF is 0. ZF has no effect.
- R10: At step 2, opcode 8 gives 11'h013 when ZF is 1 and 11'h00B when ZF is 0. CF has no effect.
- R11: Opcodes 0 and 9 to 15 give only the fetch words, with zero at steps 2 to 5. Every opcode gives zero at steps 4 and 5, and every opcode not in R4 or R5 gives zero at step 3.
- R12: `ctrl_o` bit 3 (increment) and bit 4 (load) are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 4 | Opcode of the current instruction |
| cf_i | input | 1 | Carry flag |
| zf_i | input | 1 | Zero flag |
| ctrl_o | output | 11 | Registered control word (bit layout in R3 to R12) |
| step_o | output | 6 | Registered one-hot step that `ctrl_o` belongs to |

## Verification
The bench uses the package defaults: a 4-bit opcode and six steps. With these values all sixteen opcodes can be swept in full, so every entry of the table is compared, including the no-operation opcodes. The two conditional jumps run under all four combinations of CF and ZF, which shows that each jump follows only its own flag. A reset in the middle of an instruction shows that the sequence restarts at step 0.

// File: rtl/ucode_dec_pkg.sv
`timescale 1ns/1ps
package ucode_dec_pkg;

    localparam int OPC_W      = 4;
    localparam int NUM_STEPS  = 6;
    localparam int STEP_W     = $clog2(NUM_STEPS);
    localparam int ALU_SEL_W  = 2;

    typedef enum logic [STEP_W-1:0] {
        ST_FETCH_ADDR = 3'd0,
        ST_FETCH_ADV  = 3'd1,
        ST_EXEC_A     = 3'd2,
        ST_EXEC_B     = 3'd3,
        ST_EXEC_C     = 3'd4,
        ST_EXEC_D     = 3'd5
    } step_e;

    // Field order fixes the bit positions seen by the datapath.
    typedef struct packed {
        logic [ALU_SEL_W-1:0] alu_sel; // 10:9
        logic                 alu_oe;  // 8
        logic                 out_ld;  // 7
        logic                 b_ld;    // 6
        logic                 a_ld;    // 5
        logic                 pc_ld;   // 4
        logic                 pc_inc;  // 3
        logic                 ir_ld;   // 2
        logic                 rom_oe;  // 1
        logic                 pc_oe;   // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic on_carry;
        logic on_zero;
    } cond_t;

    typedef struct packed {
        ctrl_t ctl;
        cond_t cond;
    } entry_t;

    localparam logic [ALU_SEL_W-1:0] ALU_ADD = 2'b00;
    localparam logic [ALU_SEL_W-1:0] ALU_SUB = 2'b01;

    localparam logic [OPC_W-1:0] OP_LDA = 4'd1;
    localparam logic [OPC_W-1:0] OP_LDB = 4'd2;
    localparam logic [OPC_W-1:0] OP_ADD = 4'd3;
    localparam logic [OPC_W-1:0] OP_SUB = 4'd4;
    localparam logic [OPC_W-1:0] OP_OUT = 4'd5;
    localparam logic [OPC_W-1:0] OP_JMP = 4'd6;
    localparam logic [OPC_W-1:0] OP_JC  = 4'd7;
    localparam logic [OPC_W-1:0] OP_JZ  = 4'd8;

endpackage

// File: rtl/ucode_dec_seq.sv
`timescale 1ns/1ps
module ucode_dec_seq
    import ucode_dec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    output step_e                step_o,
    output logic [NUM_STEPS-1:0] step_oh_o
);

    step_e state_q;
    step_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FETCH_ADDR: state_d = ST_FETCH_ADV;
            ST_FETCH_ADV:  state_d = ST_EXEC_A;
            ST_EXEC_A:     state_d = ST_EXEC_B;
            ST_EXEC_B:     state_d = ST_EXEC_C;
            ST_EXEC_C:     state_d = ST_EXEC_D;
            ST_EXEC_D:     state_d = ST_FETCH_ADDR;
            default:       state_d = ST_FETCH_ADDR;
        endcase
    end

    assign step_o = state_q;

    for (genvar i = 0; i < NUM_STEPS; i++) begin : g_oh
        assign step_oh_o[i] = (state_q == step_e'(i));
    end

endmodule

// File: rtl/ucode_dec_table.sv
`timescale 1ns/1ps
module ucode_dec_table
    import ucode_dec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  step_e            step_i,
    output entry_t           entry_o
);

    localparam int KEY_W = OPC_W + STEP_W;

    logic [KEY_W-1:0] key;
    assign key = {opcode_i, step_i};

    always_comb begin
        entry_o = '0;
        unique casez (key)
            {{OPC_W{1'b?}}, ST_FETCH_ADDR}: begin
                entry_o.ctl.pc_oe  = 1'b1;
                entry_o.ctl.rom_oe = 1'b1;
                entry_o.ctl.ir_ld  = 1'b1;
            end
            {{OPC_W{1'b?}}, ST_FETCH_ADV}: begin
                entry_o.ctl.pc_inc = 1'b1;
            end
            {OP_LDA, ST_EXEC_A}: begin
                entry_o.ctl.pc_oe  = 1'b1;
                entry_o.ctl.rom_oe = 1'b1;
                entry_o.ctl.a_ld   = 1'b1;
            end
            {OP_LDA, ST_EXEC_B}: begin
                entry_o.ctl.pc_inc = 1'b1;
            end
            {OP_LDB, ST_EXEC_A}: begin
                entry_o.ctl.pc_oe  = 1'b1;
                entry_o.ctl.rom_oe = 1'b1;
                entry_o.ctl.b_ld   = 1'b1;
            end
            {OP_LDB, ST_EXEC_B}: begin
                entry_o.ctl.pc_inc = 1'b1;
            end
            {OP_ADD, ST_EXEC_A}: begin
                entry_o.ctl.alu_sel = ALU_ADD;
                entry_o.ctl.alu_oe  = 1'b1;
                entry_o.ctl.a_ld    = 1'b1;
            end
            {OP_SUB, ST_EXEC_A}: begin
                entry_o.ctl.alu_sel = ALU_SUB;
                entry_o.ctl.alu_oe  = 1'b1;
                entry_o.ctl.a_ld    = 1'b1;
            end
            {OP_OUT, ST_EXEC_A}: begin
                entry_o.ctl.out_ld = 1'b1;
            end
            {OP_JMP, ST_EXEC_A}: begin
                entry_o.ctl.pc_oe  = 1'b1;
                entry_o.ctl.rom_oe = 1'b1;
                entry_o.ctl.pc_ld  = 1'b1;
            end
            {OP_JC, ST_EXEC_A}: begin
                entry_o.ctl.pc_oe      = 1'b1;
                entry_o.ctl.rom_oe     = 1'b1;
                entry_o.cond.on_carry  = 1'b1;
            end
            {OP_JZ, ST_EXEC_A}: begin
                entry_o.ctl.pc_oe      = 1'b1;
                entry_o.ctl.rom_oe     = 1'b1;
                entry_o.cond.on_zero   = 1'b1;
            end
            default: begin
                entry_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/ucode_dec_gate.sv
`timescale 1ns/1ps
module ucode_dec_gate
    import ucode_dec_pkg::*;
(
    input  entry_t entry_i,
    input  logic   cf_i,
    input  logic   zf_i,
    output ctrl_t  ctrl_o
);

    logic is_cond;
    logic take;

    assign is_cond = entry_i.cond.on_carry | entry_i.cond.on_zero;
    assign take    = (entry_i.cond.on_carry & cf_i) | (entry_i.cond.on_zero & zf_i);

    always_comb begin
        ctrl_o = entry_i.ctl;
        if (is_cond) begin
            ctrl_o.pc_ld  = take;
            ctrl_o.pc_inc = ~take;
        end
    end

endmodule

// File: rtl/ucode_decoder.sv
`timescale 1ns/1ps
module ucode_decoder
    import ucode_dec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OPC_W-1:0]     opcode_i,
    input  logic                 cf_i,
    input  logic                 zf_i,
    output logic [CTRL_W-1:0]    ctrl_o,
    output logic [NUM_STEPS-1:0] step_o
);

    step_e                step;
    logic [NUM_STEPS-1:0] step_oh;
    entry_t               entry;
    ctrl_t                ctrl_d;
    ctrl_t                ctrl_q;
    logic [NUM_STEPS-1:0] step_q;

    ucode_dec_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .step_o    (step),
        .step_oh_o (step_oh)
    );

    ucode_dec_table u_table (
        .opcode_i (opcode_i),
        .step_i   (step),
        .entry_o  (entry)
    );

    ucode_dec_gate u_gate (
        .entry_i (entry),
        .cf_i    (cf_i),
        .zf_i    (zf_i),
        .ctrl_o  (ctrl_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            step_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            step_q <= step_oh;
        end
    end

    assign ctrl_o = ctrl_q;
    assign step_o = step_q;

endmodule

// File: rtl/ucode_decoder_checker.sv
`timescale 1ns/1ps
module ucode_decoder_checker
    import ucode_dec_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [OPC_W-1:0]     opcode_i,
    input logic                 cf_i,
    input logic                 zf_i,
    input logic [CTRL_W-1:0]    ctrl_o,
    input logic [NUM_STEPS-1:0] step_o
);

    p_step_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step_o));

    p_step_adv_r2: assert property (@(posedge clk) disable iff (rst)
        step_o[0] |=> step_o[1]);

    p_step_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        step_o[NUM_STEPS-1] |=> step_o[0]);

    p_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        step_o[0] |-> ctrl_o == 11'h007);

    p_lda_r4: assert property (@(posedge clk) disable iff (rst)
        (step_o[2] && $past(opcode_i) == OP_LDA) |-> ctrl_o[5]);

    p_jc_taken_r9: assert property (@(posedge clk) disable iff (rst)
        (step_o[2] && $past(opcode_i) == OP_JC && $past(cf_i)) |-> ctrl_o[4]);

    p_jz_skip_r10: assert property (@(posedge clk) disable iff (rst)
        (step_o[2] && $past(opcode_i) == OP_JZ && !$past(zf_i)) |-> (ctrl_o[3] && !ctrl_o[4]));

    p_unused_r11: assert property (@(posedge clk) disable iff (rst)
        ((|step_o[NUM_STEPS-1:2]) && ($past(opcode_i) == 4'd0 || $past(opcode_i) > OP_JZ)) |-> ctrl_o == '0);

    p_pc_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_o[3] && ctrl_o[4]));

endmodule

bind ucode_decoder ucode_decoder_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .opcode_i (opcode_i),
    .cf_i     (cf_i),
    .zf_i     (zf_i),
    .ctrl_o   (ctrl_o),
    .step_o   (step_o)
);

// File: tb/ucode_decoder_bench.sv
`timescale 1ns/1ps
module ucode_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode = 4'd0;
    logic        cf = 1'b0;
    logic        zf = 1'b0;
    logic [10:0] ctrl_o;
    logic [5:0]  step_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [10:0] exp_ctrl_q[$];
    logic [5:0]  exp_step_q[$];
    string       exp_tag_q[$];

    always #4 clk = ~clk;

    ucode_decoder u_ucode_decoder (
        .clk      (clk),
        .rst      (rst),
        .opcode_i (opcode),
        .cf_i     (cf),
        .zf_i     (zf),
        .ctrl_o   (ctrl_o),
        .step_o   (step_o)
    );

    function automatic logic [10:0] model(input logic [3:0] op, input int p,
                                          input logic c, input logic z);
        logic [10:0] w;
        w = 11'h000;
        if (p == 0) w = 11'h007;
        else if (p == 1) w = 11'h008;
        else if (p == 2) begin
            case (op)
                4'd1: w = 11'h023;
                4'd2: w = 11'h043;
                4'd3: w = 11'h120;
                4'd4: w = 11'h320;
                4'd5: w = 11'h080;
                4'd6: w = 11'h013;
                4'd7: w = c ? 11'h013 : 11'h00B;
                4'd8: w = z ? 11'h013 : 11'h00B;
                default: w = 11'h000;
            endcase
        end else if (p == 3) begin
            if (op == 4'd1 || op == 4'd2) w = 11'h008;
        end
        return w;
    endfunction

    function automatic string tag_for(input logic [3:0] op, input int p);
        if (p < 2) return "R3";
        case (op)
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3, 4'd4: return "R6";
            4'd5: return "R7";
            4'd6: return "R8";
            4'd7: return (p == 2) ? "R9" : "R11";
            4'd8: return (p == 2) ? "R10" : "R11";
            default: return "R11";
        endcase
    endfunction

    // Driver: called at a falling edge, drives one step per cycle.
    task automatic run_op(input logic [3:0] op, input logic c, input logic z, input int n_steps);
        for (int p = 0; p < n_steps; p++) begin
            opcode = op;
            cf = c;
            zf = z;
            exp_ctrl_q.push_back(model(op, p, c, z));
            exp_step_q.push_back(6'b000001 << p);
            exp_tag_q.push_back(tag_for(op, p));
            @(negedge clk);
        end
    endtask

    task automatic check_reset_state();
        checks++;
        if (ctrl_o !== 11'h000 || step_o !== 6'h00) begin
            errors++;
            $display("FAIL R1 reset state actual ctrl=%h step=%b expected ctrl=000 step=000000",
                     ctrl_o, step_o);
        end
    endtask

    // Monitor: compares after each rising edge.
    always @(posedge clk) begin
        logic [10:0] ec;
        logic [5:0]  es;
        string       et;
        #2;
        if (exp_ctrl_q.size() != 0) begin
            ec = exp_ctrl_q.pop_front();
            es = exp_step_q.pop_front();
            et = exp_tag_q.pop_front();
            checks++;
            if (ctrl_o !== ec) begin
                errors++;
                $display("FAIL %s ctrl actual=%h expected=%h (step %b)", et, ctrl_o, ec, es);
            end
            checks++;
            if (step_o !== es) begin
                errors++;
                $display("FAIL R2 step actual=%b expected=%b", step_o, es);
            end
            checks++;
            if (ctrl_o[3] && ctrl_o[4]) begin
                errors++;
                $display("FAIL R12 inc/load actual=11 expected=not both (ctrl=%h)", ctrl_o);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check_reset_state();                   // R1
        @(negedge clk);
        rst = 1'b0;

        // R3, R11 plus each opcode: sweep all sixteen with flags low
        for (int op = 0; op < 16; op++) begin
            run_op(op[3:0], 1'b0, 1'b0, 6);
        end

        // R9, R10: both conditional jumps under every flag pair
        for (int f = 0; f < 4; f++) begin
            run_op(4'd7, f[1], f[0], 6);
            run_op(4'd8, f[1], f[0], 6);
        end

        // R4, R8: flag-independent entries with flags set
        for (int f = 1; f < 4; f++) begin
            run_op(4'd1, f[1], f[0], 6);
            run_op(4'd6, f[1], f[0], 6);
            run_op(4'd11, f[1], f[0], 6);
        end

        // R1: reset in the middle of an instruction, then restart at step 0
        run_op(4'd1, 1'b0, 1'b0, 3);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check_reset_state();
        @(posedge clk);
        #2;
        check_reset_state();
        @(negedge clk);
        rst = 1'b0;
        run_op(4'd7, 1'b1, 1'b0, 6);
        run_op(4'd4, 1'b1, 1'b1, 6);
        run_op(4'd2, 1'b0, 1'b1, 6);

        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule